// File: doc/BRIEF.md
# Shared Load-Reserved / Store-Conditional Reservation Table

This block keeps the reservations that load-reserved and store-conditional requests from several harts place on physical addresses. It is one table shared by every hart. Each slot holds an address, the ID of the hart that owns it, and a live flag. A load-reserved request creates a slot for its address, or takes over the slot at that address. A store-conditional request succeeds only when it finds a live slot for its own hart at its address, and it removes that slot when it succeeds. A yield request from a hart kills every reservation that hart owns. The killed slots stay in the table and are recycled only when the table is full.

Requests arrive on a single port that carries a strobe, an operation code, a physical address, an access size, a hart ID and a flag marking the target as I/O space. Every request gets a response one cycle later: a response strobe plus pulses for store-conditional success, load access fault, store access fault and misaligned fault. Address translation, the memory data path and the store itself are handled outside this block.

Top module: `resv_table`

## Requirements
- R1: After reset the table holds no reservations and every response output is low. A store-conditional issued right after reset fails with no fault.
- R2: A load-reserved request (op 0) with no fault records its address with the requesting hart as a live reservation. A later store-conditional (op 1) from that hart to that address pulses sc_ok_o.
- R3: A load-reserved request to an address reserved by another hart takes over that slot. A store-conditional from the previous owner then fails, and one from the new owner succeeds.
- R4: A load-reserved request from a hart that already holds a live reservation at the same address pulses load_fault_o and leaves that reservation intact.
- R5: A successful store-conditional deletes its reservation, so an identical store-conditional issued next fails.
- R6: A store-conditional with no matching live reservation for its hart fails with no fault pulse and does not change the table.
- R7: A store-conditional whose address is not a multiple of its size (size code 0/1/2/3 = 1/2/4/8 bytes) pulses misalign_fault_o and no other result. This check takes priority over the I/O check, and the table is left unchanged.
- R8: A yield request (op 2) makes every reservation owned by its hart unusable. Reservations owned by other harts still succeed.
- R9: With req_io_i high, a load-reserved request pulses load_fault_o and an aligned store-conditional pulses store_fault_o. Neither touches the table.
- R10: The number of slots in use never exceeds the effective capacity. The effective capacity is CAP_CFG limited to ENTRIES, and a CAP_CFG of 0 counts as 1. A load-reserved request to a new address while the table is at capacity and holds no killed slot pulses load_fault_o.
- R11: When the table is at capacity, a load-reserved request to a new address reuses the lowest killed slot and succeeds. A reservation that was killed before does not revive.
- R12: resp_valid_o pulses for exactly one cycle, one cycle after each request. Op 3 gets a response with every result low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 2 | 0 load-reserved, 1 store-conditional, 2 yield, 3 none |
| req_addr_i | input | ADDR_W | Physical address |
| req_size_i | input | 2 | Access size code, 2^code bytes |
| req_hart_i | input | $clog2(N_HARTS) | Requesting hart |
| req_io_i | input | 1 | Target is I/O space |
| resp_valid_o | output | 1 | Response strobe |
| sc_ok_o | output | 1 | Store-conditional succeeded |
| load_fault_o | output | 1 | Load access fault |
| store_fault_o | output | 1 | Store access fault |
| misalign_fault_o | output | 1 | Store address misaligned |

## Verification
Every result comes from one register stage, so each response is due exactly one clock edge after the edge that captures the request. Table changes take effect at that same edge, so they become visible to the next request. The bench drives each request on a falling edge and samples the response on the following falling edge. One idle cycle after that, it confirms the response strobe has dropped. Effects on the table, such as takeover, deletion, killing and reuse, are observed through later store-conditional results, never by looking inside the design.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    OP_LR    = 2'd0,
    OP_SC    = 2'd1,
    OP_YIELD = 2'd2,
    OP_NONE  = 2'd3
  } resv_op_e;

  typedef struct packed {
    logic sc_ok;
    logic load_fault;
    logic store_fault;
    logic misalign;
  } resv_resp_t;
endpackage

// File: rtl/resv_match.sv
module resv_match #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int HART_W  = 2,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             present_i,
  input  logic [ENTRIES-1:0]             live_i,
  input  logic [ENTRIES-1:0][ADDR_W-1:0] addr_i,
  input  logic [ENTRIES-1:0][HART_W-1:0] hart_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [HART_W-1:0]              req_hart_i,
  output logic [ENTRIES-1:0]             hit_o,
  output logic                           hit_any_o,
  output logic [IDX_W-1:0]               hit_idx_o,
  output logic                           hit_own_live_o,
  output logic [ENTRIES-1:0]             owned_o
);
  logic [ENTRIES-1:0] own_live;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_o[g]    = present_i[g] && (addr_i[g] == req_addr_i);
    assign owned_o[g]  = present_i[g] && (hart_i[g] == req_hart_i);
    assign own_live[g] = hit_o[g] && owned_o[g] && live_i[g];
  end

  assign hit_any_o      = |hit_o;
  assign hit_own_live_o = |own_live;

  always_comb begin
    hit_idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (hit_o[i]) hit_idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/resv_alloc.sv
module resv_alloc #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0] present_i,
  input  logic [ENTRIES-1:0] live_i,
  output logic               free_any_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic               dead_any_o,
  output logic [IDX_W-1:0]   dead_idx_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [ENTRIES-1:0] dead;
  assign dead       = present_i & ~live_i;
  assign free_any_o = ~&present_i;
  assign dead_any_o = |dead;

  // lowest index wins
  always_comb begin
    free_idx_o = '0;
    dead_idx_o = '0;
    count_o    = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!present_i[i]) free_idx_o = IDX_W'(i);
      if (dead[i])       dead_idx_o = IDX_W'(i);
    end
    for (int i = 0; i < ENTRIES; i++)
      count_o = count_o + CNT_W'(present_i[i]);
  end
endmodule

// File: rtl/resv_table.sv
module resv_table
  import resv_pkg::*;
#(
  parameter int N_HARTS = 4,
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int CAP_CFG = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_valid_i,
  input  logic [1:0]                 req_op_i,
  input  logic [ADDR_W-1:0]          req_addr_i,
  input  logic [1:0]                 req_size_i,
  input  logic [$clog2(N_HARTS)-1:0] req_hart_i,
  input  logic                       req_io_i,
  output logic                       resp_valid_o,
  output logic                       sc_ok_o,
  output logic                       load_fault_o,
  output logic                       store_fault_o,
  output logic                       misalign_fault_o
);
  localparam int HART_W  = $clog2(N_HARTS);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam int CAP_EFF = (CAP_CFG == 0) ? 1 : ((CAP_CFG > ENTRIES) ? ENTRIES : CAP_CFG);

  logic [ENTRIES-1:0]             ent_present_q, ent_live_q;
  logic [ENTRIES-1:0][ADDR_W-1:0] ent_addr_q;
  logic [ENTRIES-1:0][HART_W-1:0] ent_hart_q;

  logic [ENTRIES-1:0] hit, owned;
  logic               hit_any, hit_own_live, free_any, dead_any;
  logic [IDX_W-1:0]   hit_idx, free_idx, dead_idx;
  logic [CNT_W-1:0]   count;

  resv_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .HART_W(HART_W)) u_match (
    .present_i     (ent_present_q),
    .live_i        (ent_live_q),
    .addr_i        (ent_addr_q),
    .hart_i        (ent_hart_q),
    .req_addr_i    (req_addr_i),
    .req_hart_i    (req_hart_i),
    .hit_o         (hit),
    .hit_any_o     (hit_any),
    .hit_idx_o     (hit_idx),
    .hit_own_live_o(hit_own_live),
    .owned_o       (owned)
  );

  resv_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .present_i (ent_present_q),
    .live_i    (ent_live_q),
    .free_any_o(free_any),
    .free_idx_o(free_idx),
    .dead_any_o(dead_any),
    .dead_idx_o(dead_idx),
    .count_o   (count)
  );

  resv_op_e   op;
  resv_resp_t resp_d, resp_q;
  logic       misal, wr_en, clr_en;
  logic [IDX_W-1:0]   wr_idx;
  logic [ENTRIES-1:0] kill_mask;

  assign op = resv_op_e'(req_op_i);

  always_comb begin
    case (req_size_i)
      2'd0:    misal = 1'b0;
      2'd1:    misal = req_addr_i[0];
      2'd2:    misal = |req_addr_i[1:0];
      default: misal = |req_addr_i[2:0];
    endcase
  end

  always_comb begin
    resp_d    = '0;
    wr_en     = 1'b0;
    wr_idx    = hit_idx;
    clr_en    = 1'b0;
    kill_mask = '0;
    if (req_valid_i) begin
      case (op)
        OP_LR: begin
          if (req_io_i)          resp_d.load_fault = 1'b1;
          else if (hit_any) begin
            if (hit_own_live)    resp_d.load_fault = 1'b1;  // nested
            else                 wr_en = 1'b1;              // take over
          end else if (free_any && (count < CNT_W'(CAP_EFF))) begin
            wr_en  = 1'b1;
            wr_idx = free_idx;
          end else if (dead_any) begin
            wr_en  = 1'b1;
            wr_idx = dead_idx;
          end else               resp_d.load_fault = 1'b1;
        end
        OP_SC: begin
          if (misal)             resp_d.misalign    = 1'b1;
          else if (req_io_i)     resp_d.store_fault = 1'b1;
          else if (hit_own_live) begin
            resp_d.sc_ok = 1'b1;
            clr_en       = 1'b1;
          end
        end
        OP_YIELD: kill_mask = owned;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_present_q <= '0;
      ent_live_q    <= '0;
      ent_addr_q    <= '0;
      ent_hart_q    <= '0;
      resp_q        <= '0;
      resp_valid_o  <= 1'b0;
    end else begin
      resp_q       <= resp_d;
      resp_valid_o <= req_valid_i;
      ent_live_q   <= ent_live_q & ~kill_mask;
      if (wr_en) begin
        ent_present_q[wr_idx] <= 1'b1;
        ent_live_q[wr_idx]    <= 1'b1;
        ent_addr_q[wr_idx]    <= req_addr_i;
        ent_hart_q[wr_idx]    <= req_hart_i;
      end
      if (clr_en) begin
        ent_present_q[hit_idx] <= 1'b0;
        ent_live_q[hit_idx]    <= 1'b0;
      end
    end
  end

  assign sc_ok_o          = resp_q.sc_ok;
  assign load_fault_o     = resp_q.load_fault;
  assign store_fault_o    = resp_q.store_fault;
  assign misalign_fault_o = resp_q.misalign;

  AST_RESULT_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sc_ok_o || load_fault_o || store_fault_o || misalign_fault_o) |-> resp_valid_o); // R12
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sc_ok_o, load_fault_o, store_fault_o, misalign_fault_o})); // R7
  AST_UNIQUE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit) <= 1); // R3
  AST_WITHIN_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(CAP_EFF)); // R10
  AST_SC_DELETES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_ok_o |-> (count == $past(count) - CNT_W'(1))); // R5
  AST_FAULT_KEEPS_TABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_fault_o || store_fault_o || misalign_fault_o) |->
      ($stable(ent_present_q) && $stable(ent_live_q))); // R9
endmodule

// File: tb/resv_table_tb.sv
module resv_table_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        v0, v1, io;
  logic [1:0]  op, size, hart;
  logic [31:0] addr;
  logic        rv0, ok0, lf0, sf0, mf0;
  logic        rv1, ok1, lf1, sf1, mf1;

  resv_table dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v0), .req_op_i(op),
    .req_addr_i(addr), .req_size_i(size), .req_hart_i(hart), .req_io_i(io),
    .resp_valid_o(rv0), .sc_ok_o(ok0), .load_fault_o(lf0),
    .store_fault_o(sf0), .misalign_fault_o(mf0));

  resv_table #(.CAP_CFG(0)) dut_z (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(v1), .req_op_i(op),
    .req_addr_i(addr), .req_size_i(size), .req_hart_i(hart), .req_io_i(io),
    .resp_valid_o(rv1), .sc_ok_o(ok1), .load_fault_o(lf1),
    .store_fault_o(sf1), .misalign_fault_o(mf1));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // exp = {resp_valid, sc_ok, load_fault, store_fault, misalign}
  task automatic issue(input bit sel, input logic [1:0] o, input logic [31:0] a,
                       input logic [1:0] s, input logic [1:0] h, input bit i,
                       input logic [3:0] exp, input string req);
    logic [4:0] act;
    @(negedge clk);
    op = o; addr = a; size = s; hart = h; io = i;
    if (sel) v1 = 1'b1; else v0 = 1'b1;
    @(negedge clk);
    v0 = 1'b0; v1 = 1'b0;
    act = sel ? {rv1, ok1, lf1, sf1, mf1} : {rv0, ok0, lf0, sf0, mf0};
    check(act == {1'b1, exp}, req, int'(act), int'({1'b1, exp}));
  endtask

  // {op, addr[15:0], size, hart, io, exp(sc,lf,sf,mf)}
  localparam int NV = 22;
  localparam logic [26:0] VEC [NV] = '{
    {2'd1, 16'h0100, 2'd2, 2'd0, 1'b0, 4'b0000},  // R1 empty table
    {2'd0, 16'h0100, 2'd2, 2'd0, 1'b0, 4'b0000},  // R2
    {2'd0, 16'h0100, 2'd2, 2'd0, 1'b0, 4'b0100},  // R4 nested
    {2'd1, 16'h0100, 2'd2, 2'd1, 1'b0, 4'b0000},  // R6 wrong hart
    {2'd1, 16'h0100, 2'd2, 2'd0, 1'b0, 4'b1000},  // R2 / R4 intact
    {2'd1, 16'h0100, 2'd2, 2'd0, 1'b0, 4'b0000},  // R5 deleted
    {2'd0, 16'h0200, 2'd3, 2'd1, 1'b0, 4'b0000},  // R3
    {2'd0, 16'h0200, 2'd3, 2'd2, 1'b0, 4'b0000},  // R3 takeover
    {2'd1, 16'h0200, 2'd3, 2'd1, 1'b0, 4'b0000},  // R3 old owner
    {2'd1, 16'h0200, 2'd3, 2'd2, 1'b0, 4'b1000},  // R3 new owner
    {2'd1, 16'h0102, 2'd2, 2'd0, 1'b0, 4'b0001},  // R7 word misaligned
    {2'd1, 16'h0103, 2'd1, 2'd0, 1'b1, 4'b0001},  // R7 beats io
    {2'd0, 16'h0300, 2'd2, 2'd0, 1'b1, 4'b0100},  // R9 lr io
    {2'd1, 16'h0300, 2'd2, 2'd0, 1'b1, 4'b0010},  // R9 sc io
    {2'd1, 16'h0300, 2'd2, 2'd0, 1'b0, 4'b0000},  // R9 untouched
    {2'd0, 16'h0400, 2'd2, 2'd3, 1'b0, 4'b0000},  // R8 setup
    {2'd0, 16'h0500, 2'd2, 2'd0, 1'b0, 4'b0000},  // R8 setup
    {2'd2, 16'h0000, 2'd0, 2'd3, 1'b0, 4'b0000},  // R8 yield
    {2'd1, 16'h0400, 2'd2, 2'd3, 1'b0, 4'b0000},  // R8 killed
    {2'd1, 16'h0500, 2'd2, 2'd0, 1'b0, 4'b1000},  // R8 other hart
    {2'd3, 16'h0500, 2'd2, 2'd0, 1'b0, 4'b0000},  // R12 op 3
    {2'd1, 16'h0108, 2'd3, 2'd0, 1'b0, 4'b0000}   // R7 aligned dword, R6
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    v0 = 0; v1 = 0; op = 0; addr = 0; size = 0; hart = 0; io = 0;
    repeat (3) @(negedge clk);
    check({rv0, ok0, lf0, sf0, mf0} == 5'b0, "R1 reset outputs", int'({rv0, ok0, lf0, sf0, mf0}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({rv0, rv1} == 2'b0, "R1 idle after reset", int'({rv0, rv1}), 0);

    for (int k = 0; k < NV; k++)
      issue(1'b0, VEC[k][26:25], {16'h0, VEC[k][24:9]}, VEC[k][8:7], VEC[k][6:5],
            VEC[k][4], VEC[k][3:0], $sformatf("vector %0d", k));

    @(negedge clk);
    check(rv0 == 1'b0, "R12 single pulse", int'(rv0), 0);

    // table: 0x400 killed (hart 3); fill the remaining seven slots
    for (int k = 0; k < 7; k++)
      issue(1'b0, 2'd0, 32'h1000 + 32'(k * 8), 2'd3, 2'd0, 1'b0, 4'b0000, "R10 fill");
    issue(1'b0, 2'd0, 32'h2000, 2'd3, 2'd1, 1'b0, 4'b0000, "R11 reuse killed slot");
    issue(1'b0, 2'd0, 32'h2008, 2'd3, 2'd1, 1'b0, 4'b0100, "R10 full");
    issue(1'b0, 2'd1, 32'h0400, 2'd2, 2'd3, 1'b0, 4'b0000, "R11 killed gone");
    issue(1'b0, 2'd1, 32'h2000, 2'd3, 2'd1, 1'b0, 4'b1000, "R11 reused slot live");
    issue(1'b0, 2'd0, 32'h2008, 2'd3, 2'd1, 1'b0, 4'b0000, "R10 room again");

    // capacity 0 treated as 1
    issue(1'b1, 2'd0, 32'h0010, 2'd2, 2'd0, 1'b0, 4'b0000, "R10 cap0 first");
    issue(1'b1, 2'd0, 32'h0020, 2'd2, 2'd1, 1'b0, 4'b0100, "R10 cap0 full");
    issue(1'b1, 2'd1, 32'h0020, 2'd2, 2'd1, 1'b0, 4'b0000, "R10 cap0 no entry");
    issue(1'b1, 2'd1, 32'h0010, 2'd2, 2'd0, 1'b0, 4'b1000, "R10 cap0 kept");

    // reset clears the table
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    issue(1'b0, 2'd1, 32'h2008, 2'd3, 2'd1, 1'b0, 4'b0000, "R1 cleared by reset");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule